// File: doc/BRIEF.md
# SYSREF-Aligned Multiframe Counter

This block keeps a local multiframe count for a serial link receiver. The count runs on the link clock, advancing once per cycle, and wraps after a parameterised number of counts (`MF_LEN`, eight by default). A SYSREF pulse fixes the phase of the count. The pulse is first registered, then edge-detected, and the count is forced to zero a fixed two link clocks after the edge at which SYSREF was first sampled high. This gives every receiver that shares SYSREF the same multiframe phase with a deterministic delay.

Between SYSREF events the count runs free. A later SYSREF whose restart would land exactly where the count wraps anyway leaves the phase untouched. A SYSREF with any other phase re-aligns the count and sets a sticky flag, so the system can see that the timing reference moved.

The block also drives the active-low sync request towards the transmitter. The request stays asserted until the receiver reports that it is ready to leave code-group synchronisation and the count has been aligned at least once. It is then released only on the cycle in which the count returns to zero.

Top module: `mf_align_top`

## Requirements
- R1: SYSREF is registered before any use and is edge-detected, so a pulse held high for several cycles causes exactly one restart of the count.
- R2: The count reads zero after the second rising clock edge that follows the edge at which SYSREF is first sampled high.
- R3: Outside a restart, the count advances by one per clock from 0 to MF_LEN-1 and then wraps to 0.
- R4: `mf_start_o` is high exactly in the cycles in which `mf_count_o` is 0.
- R5: A SYSREF whose restart falls on the edge where the count would wrap to 0 anyway (count MF_LEN-1 before that edge) leaves the count sequence unchanged and does not set `phase_moved_o`.
- R6: Once aligned, a SYSREF with any other phase restarts the count and sets `phase_moved_o`, which stays high until reset.
- R7: The first SYSREF after reset sets `aligned_o` to 1 and does not set `phase_moved_o`.
- R8: `sync_req_n_o` goes high only on the edge at which the count becomes 0, and only when `link_ready_i` is high and the count is aligned; with `link_ready_i` high before alignment it stays low.
- R9: When `link_ready_i` is low at a clock edge, `sync_req_n_o` is low after that edge.
- R10: While `rst` is high, the count is 0, `mf_start_o` is 1, and `sync_req_n_o`, `aligned_o` and `phase_moved_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous active-high reset |
| sysref_i | input | 1 | SYSREF timing reference |
| link_ready_i | input | 1 | Receiver is ready to leave code-group synchronisation |
| mf_count_o | output | $clog2(MF_LEN) | Current multiframe count |
| mf_start_o | output | 1 | High while the count is 0 |
| sync_req_n_o | output | 1 | Active-low sync request to the transmitter |
| aligned_o | output | 1 | Count has been phase-set by SYSREF since reset |
| phase_moved_o | output | 1 | Sticky flag: a SYSREF shifted an established phase |

## Verification
A wrong restart delay or a lost edge detect shows at `mf_count_o` within three cycles of the SYSREF edge, as a zero one cycle early or late, or as zeros repeated while a wide pulse is held. A wrong alignment decision shows at `phase_moved_o` three cycles after the pulse, and as a count that no longer matches the expected phase from then on. A sync release off the boundary shows at `sync_req_n_o` rising while the count is not 0. A missed release shows as the request still low one cycle after the count reaches 0.

// File: rtl/mf_align_pkg.sv
package mf_align_pkg;

    // Sync request controller states
    typedef enum logic [1:0] {
        SYNC_HOLD  = 2'd0,   // request asserted, receiver not ready
        SYNC_ARMED = 2'd1,   // receiver ready, waiting for a boundary
        SYNC_RUN   = 2'd2    // request released
    } sync_state_e;

    // Wrapping increment of a count with terminal value `last`
    function automatic int unsigned wrap_inc(input int unsigned c, input int unsigned last);
        return (c >= last) ? 0 : c + 1;
    endfunction

    // Decide whether a restart request moves an established phase
    function automatic logic phase_shifts(input logic was_aligned, input logic at_last);
        return was_aligned && !at_last;
    endfunction

endpackage

// File: rtl/mf_sysref_capture.sv
module mf_sysref_capture #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sysref_i,
    output logic load_o
);
    localparam int PIPE_W = (STAGES < 2) ? 2 : STAGES;

    // capture register and its delayed copy
    logic cap_q;
    logic cap_d;
    logic edge_c;
    logic [PIPE_W-2:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= 1'b0;
            cap_d <= 1'b0;
        end else begin
            cap_q <= sysref_i;
            cap_d <= cap_q;
        end
    end

    assign edge_c = cap_q && !cap_d;

    // delay line: the restart takes effect STAGES edges after capture
    generate
        if (PIPE_W == 2) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) pipe_q <= '0;
                else     pipe_q <= edge_c;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) pipe_q <= '0;
                else     pipe_q <= {pipe_q[PIPE_W-3:0], edge_c};
            end
        end
    endgenerate

    assign load_o = pipe_q[PIPE_W-2];

    // R1: edge detection never yields two restarts on back-to-back cycles
    a_r1_single_load: assert property (@(posedge clk) disable iff (rst)
        load_o |=> !load_o);

endmodule

// File: rtl/mf_phase_counter.sv
module mf_phase_counter
    import mf_align_pkg::*;
#(
    parameter int MF_LEN = 8,
    localparam int CNT_W = (MF_LEN > 2) ? $clog2(MF_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    output logic [CNT_W-1:0] count_o,
    output logic             boundary_o,
    output logic             wrap_next_o,
    output logic             aligned_o,
    output logic             moved_o
);
    localparam int unsigned LAST = MF_LEN - 1;
    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(LAST);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             boundary;
        logic             aligned;
        logic             moved;
    } cnt_state_t;

    cnt_state_t st_q, st_n;
    logic       at_last;

    assign at_last = (st_q.count == LAST_V);

    always_comb begin
        st_n       = st_q;
        st_n.count = CNT_W'(wrap_inc(int'(st_q.count), LAST));
        if (load_i) begin
            st_n.count   = '0;
            st_n.aligned = 1'b1;
            if (phase_shifts(st_q.aligned, at_last))
                st_n.moved = 1'b1;
        end
        st_n.boundary = (st_n.count == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.count    <= '0;
            st_q.boundary <= 1'b1;
            st_q.aligned  <= 1'b0;
            st_q.moved    <= 1'b0;
        end else begin
            st_q <= st_n;
        end
    end

    assign count_o     = st_q.count;
    assign boundary_o  = st_q.boundary;
    assign wrap_next_o = (st_n.count == '0);
    assign aligned_o   = st_q.aligned;
    assign moved_o     = st_q.moved;

    // R3: free-running step with wrap
    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        (!load_i && st_q.count != LAST_V) |=> (st_q.count == $past(st_q.count) + 1'b1));
    a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        (!load_i && st_q.count == LAST_V) |=> (st_q.count == '0));
    // R4: boundary strobe tracks the zero count
    a_r4_strobe: assert property (@(posedge clk) disable iff (rst)
        st_q.boundary == (st_q.count == '0));
    // R5: an in-phase restart keeps the flag where it was
    a_r5_in_phase: assert property (@(posedge clk) disable iff (rst)
        (load_i && st_q.aligned && at_last) |=> $stable(st_q.moved));
    // R6: sticky flag never drops outside reset
    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        !$fell(st_q.moved));
    // R7: first restart aligns without raising the flag
    a_r7_first: assert property (@(posedge clk) disable iff (rst)
        (load_i && !st_q.aligned && !st_q.moved) |=> (st_q.aligned && !st_q.moved));
    // R10: reset clears the state
    a_r10_reset: assert property (@(posedge clk)
        rst |=> (st_q.count == '0 && !st_q.aligned && !st_q.moved));

endmodule

// File: rtl/mf_sync_ctrl.sv
module mf_sync_ctrl
    import mf_align_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ready_i,
    input  logic aligned_i,
    input  logic wrap_next_i,
    input  logic boundary_i,
    output logic sync_n_o
);
    sync_state_e state_q, state_n;

    always_comb begin
        state_n = state_q;
        if (!ready_i) begin
            state_n = SYNC_HOLD;
        end else begin
            unique case (state_q)
                SYNC_HOLD, SYNC_ARMED: begin
                    if (aligned_i && wrap_next_i) state_n = SYNC_RUN;
                    else                          state_n = SYNC_ARMED;
                end
                SYNC_RUN: state_n = SYNC_RUN;
                default:  state_n = SYNC_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SYNC_HOLD;
        else     state_q <= state_n;
    end

    assign sync_n_o = (state_q == SYNC_RUN);

    // R8: release only lands on a multiframe boundary
    a_r8_on_boundary: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_n_o) |-> boundary_i);
    // R9: readiness lost means request asserted after the edge
    a_r9_drop: assert property (@(posedge clk) disable iff (rst)
        !ready_i |=> !sync_n_o);
    // R10: request held during reset
    a_r10_sync_reset: assert property (@(posedge clk)
        rst |=> !sync_n_o);

endmodule

// File: rtl/mf_align_top.sv
module mf_align_top
    import mf_align_pkg::*;
#(
    parameter int MF_LEN = 8,
    parameter int RESTART_DELAY = 2,
    localparam int CNT_W = (MF_LEN > 2) ? $clog2(MF_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sysref_i,
    input  logic             link_ready_i,
    output logic [CNT_W-1:0] mf_count_o,
    output logic             mf_start_o,
    output logic             sync_req_n_o,
    output logic             aligned_o,
    output logic             phase_moved_o
);
    logic load;
    logic wrap_next;

    mf_sysref_capture #(.STAGES(RESTART_DELAY)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .sysref_i (sysref_i),
        .load_o   (load)
    );

    mf_phase_counter #(.MF_LEN(MF_LEN)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .load_i      (load),
        .count_o     (mf_count_o),
        .boundary_o  (mf_start_o),
        .wrap_next_o (wrap_next),
        .aligned_o   (aligned_o),
        .moved_o     (phase_moved_o)
    );

    mf_sync_ctrl u_sync (
        .clk         (clk),
        .rst         (rst),
        .ready_i     (link_ready_i),
        .aligned_i   (aligned_o),
        .wrap_next_i (wrap_next),
        .boundary_i  (mf_start_o),
        .sync_n_o    (sync_req_n_o)
    );

    // R2: a restart from the capture path zeroes the count on the next edge
    a_r2_restart: assert property (@(posedge clk) disable iff (rst)
        load |=> (mf_count_o == '0));
    // R7: alignment is never lost outside reset
    a_r7_aligned_hold: assert property (@(posedge clk) disable iff (rst)
        !$fell(aligned_o));

endmodule

// File: tb/sim_mf_align_top.sv
`timescale 1ns/1ps
module sim_mf_align_top;
    localparam int MF = 8;
    localparam int CW = $clog2(MF);
    localparam int NVEC = 6;
    // stimulus table: count at which SYSREF is raised, pulse width, expected flag after
    localparam int VEC_PHASE [NVEC] = '{3, 5, 5, 2, 5, 0};
    localparam int VEC_WIDTH [NVEC] = '{1, 1, 4, 1, 1, 6};
    localparam int VEC_MOVED [NVEC] = '{0, 0, 0, 1, 1, 1};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sysref = 1'b0;
    logic ready = 1'b0;
    logic [CW-1:0] cnt;
    logic start, sync_n, aligned, moved;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    mf_align_top #(.MF_LEN(MF)) u0 (
        .clk           (clk),
        .rst           (rst),
        .sysref_i      (sysref),
        .link_ready_i  (ready),
        .mf_count_o    (cnt),
        .mf_start_o    (start),
        .sync_req_n_o  (sync_n),
        .aligned_o     (aligned),
        .phase_moved_o (moved)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        #(4 * 20000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10 count", int'(cnt), 0);
        chk("R10 start", int'(start), 1);
        chk("R10 sync", int'(sync_n), 0);
        chk("R10 aligned", int'(aligned), 0);
        chk("R10 moved", int'(moved), 0);
        rst = 1'b0;

        // R8: ready before alignment keeps the request asserted
        ready = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk("R8 unaligned hold", int'(sync_n), 0);
        end
        ready = 1'b0;
        @(negedge clk);

        // table walk: R1 R2 R3 R4 R5 R6 R7
        for (int v = 0; v < NVEC; v++) begin
            for (int g = 0; g < 2 * MF && int'(cnt) != VEC_PHASE[v]; g++) @(negedge clk);
            chk("R3 reach phase", int'(cnt), VEC_PHASE[v]);
            sysref = 1'b1;
            for (int i = 1; i <= 12; i++) begin
                @(negedge clk);
                if (i == VEC_WIDTH[v]) sysref = 1'b0;
                if (i == 3) chk("R2 zero after two edges", int'(cnt), 0);
                if (i >= 3) begin
                    chk("R1 R3 count sequence", int'(cnt), (i - 3) % MF);
                    chk("R4 start strobe", int'(start), ((i - 3) % MF == 0) ? 1 : 0);
                end
            end
            chk("R7 aligned", int'(aligned), 1);
            chk(VEC_MOVED[v] != 0 ? "R6 moved flag" : "R5 R7 moved flag", int'(moved), VEC_MOVED[v]);
        end

        // R8: ready raised mid multiframe waits for the boundary
        for (int g = 0; g < 2 * MF && int'(cnt) != 3; g++) @(negedge clk);
        ready = 1'b1;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            chk("R8 count", int'(cnt), (3 + i) % MF);
            chk("R8 release at boundary", int'(sync_n), (i >= 5) ? 1 : 0);
        end
        // R9: drop readiness
        ready = 1'b0;
        @(negedge clk);
        chk("R9 request reasserted", int'(sync_n), 0);

        // R8: ready raised when count is last releases at the very next edge
        for (int g = 0; g < 2 * MF && int'(cnt) != MF - 1; g++) @(negedge clk);
        ready = 1'b1;
        @(negedge clk);
        chk("R8 count zero", int'(cnt), 0);
        chk("R8 immediate release", int'(sync_n), 1);
        @(negedge clk);
        chk("R8 stays released", int'(sync_n), 1);

        // R10: reset mid-run clears everything
        rst = 1'b1;
        sysref = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R10 count", int'(cnt), 0);
            chk("R10 sync", int'(sync_n), 0);
            chk("R10 moved", int'(moved), 0);
            chk("R10 aligned", int'(aligned), 0);
            chk("R10 start", int'(start), 1);
        end
        sysref = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk("R3 runs after reset", int'(cnt), 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule